// File: doc/BRIEF.md
# Receive-Side Pause/Resume Detector and Transmit Gate

This block sits behind a serial receiver. It looks at every byte that the receiver delivers and compares it with two pause characters and two resume characters that software has programmed. A pause match closes a transmit-enable gate, which stops the local transmitter. A resume match opens the gate again. A pause never cuts a character short. While the shifter reports that a character is in flight, the pause is held pending and only takes hold once the shifter goes idle.

The block also decides whether each received byte goes on to the receive FIFO. Characters consumed as pause or resume are dropped. There is one exception, an optional special-character detector. When that detector is on, a byte equal to the second pause character is always stored. It also raises a sticky interrupt request, which stays up until a clear strobe arrives. The shifter, the FIFO and interrupt prioritisation live elsewhere.

Top module: `rxfc_gate`

## Requirements
- R1: After reset `tx_allow` is 1, and `push_fifo` and `irq` are 0.
- R2: Detection is active only when all of these hold: `enh_en`=1, `nine_bit`=0, `rx_mode`≠00, and the pair (`rx_mode`=11, `tx_mode` not 01 or 10) is absent. While detection is inactive, `tx_allow` is 1 from the next cycle, any pending pause is dropped, and every valid byte is pushed.
- R3: `rx_mode`=01 compares against `pause_b`/`resume_b`. `rx_mode`=10 compares against `pause_a`/`resume_a`. `rx_mode`=11 accepts either pause and either resume character.
- R4: A pause match while `tx_busy`=0 drives `tx_allow` to 0 in the next cycle.
- R5: A pause match while `tx_busy`=1 leaves `tx_allow` unchanged. `tx_allow` falls at the first later clock edge that samples `tx_busy`=0, unless a resume match arrives first.
- R6: A resume match drives `tx_allow` to 1 in the next cycle and cancels a pending pause. A byte that matches both a pause and a resume character counts as a pause.
- R7: `push_fifo` is a one-cycle pulse in the cycle after each `rx_vld`. It is suppressed for a byte matched as pause or resume while detection is active.
- R8: With `enh_en`=1 and `spec_en`=1, a byte equal to `pause_b` is a special hit. It is always pushed, even when it is also consumed as a pause.
- R9: A special hit with `spec_ie`=1 sets `irq` in the next cycle. `irq` then stays 1 until a cycle with `irq_clr`=1 and no new hit. When a hit and a clear fall in the same cycle, the hit wins. With `spec_ie`=0 a special hit does not set `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Received byte strobe |
| rx_byte | input | DW | Received byte |
| pause_a | input | DW | First pause character |
| pause_b | input | DW | Second pause character (also the special character) |
| resume_a | input | DW | First resume character |
| resume_b | input | DW | Second resume character |
| rx_mode | input | 2 | Receive flow-control mode |
| tx_mode | input | 2 | Transmit flow-control mode (qualifies mode 11) |
| enh_en | input | 1 | Enhanced features enable |
| spec_en | input | 1 | Special-character detect enable |
| spec_ie | input | 1 | Special-character interrupt enable |
| nine_bit | input | 1 | 9-bit data mode, disables detection |
| tx_busy | input | 1 | Shifter is sending a character |
| irq_clr | input | 1 | Clears the interrupt request (status read) |
| tx_allow | output | 1 | Transmitter may start a character |
| push_fifo | output | 1 | Write the byte to the receive FIFO |
| irq | output | 1 | Special-character interrupt request |

## Verification
Two events can fall in the same cycle. The first case is a pause match that arrives while `tx_busy` falls, so the pending pause and the idle shifter meet at one edge. The second case is a special hit that arrives together with `irq_clr`, where the hit has to win. Random traffic draws most bytes from the four programmed characters and sometimes makes the pause and resume characters equal. `tx_busy` and `irq_clr` toggle freely, so both collisions occur often. Directed sequences also force each collision explicitly. A bench model derived from the requirements judges every cycle and checks all three outputs.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

  typedef enum logic [1:0] {
    FC_OFF  = 2'b00,
    FC_SETB = 2'b01,
    FC_SETA = 2'b10,
    FC_BOTH = 2'b11
  } fc_mode_e;

  // Detection is live only for a valid mode combination outside 9-bit mode.
  function automatic logic fc_enabled(input logic enh, input logic nine,
                                      input logic [1:0] rxm, input logic [1:0] txm);
    logic tx_single;
    tx_single = (txm == 2'b01) || (txm == 2'b10);
    if (!enh || nine)          return 1'b0;
    if (rxm == FC_OFF)         return 1'b0;
    if (rxm == FC_BOTH)        return tx_single;
    return 1'b1;
  endfunction

  function automatic logic use_set_a(input logic [1:0] rxm);
    return (rxm == FC_SETA) || (rxm == FC_BOTH);
  endfunction

  function automatic logic use_set_b(input logic [1:0] rxm);
    return (rxm == FC_SETB) || (rxm == FC_BOTH);
  endfunction

endpackage

// File: rtl/rxfc_match.sv
module rxfc_match
  import rxfc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          rx_vld,
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] pause_a,
  input  logic [DW-1:0] pause_b,
  input  logic [DW-1:0] resume_a,
  input  logic [DW-1:0] resume_b,
  input  logic [1:0]    rx_mode,
  input  logic [1:0]    tx_mode,
  input  logic          enh_en,
  input  logic          spec_en,
  input  logic          nine_bit,
  output logic          fc_on,
  output logic          pause_hit,
  output logic          resume_hit,
  output logic          spec_hit
);
  localparam int NCH = 2;

  logic [NCH-1:0] set_on;
  logic [NCH-1:0] p_eq;
  logic [NCH-1:0] r_eq;
  logic [DW-1:0]  p_chr [NCH];
  logic [DW-1:0]  r_chr [NCH];

  always_comb begin
    p_chr[0] = pause_a;
    p_chr[1] = pause_b;
    r_chr[0] = resume_a;
    r_chr[1] = resume_b;
    set_on[0] = use_set_a(rx_mode);
    set_on[1] = use_set_b(rx_mode);
  end

  for (genvar gi = 0; gi < NCH; gi++) begin : g_cmp
    assign p_eq[gi] = set_on[gi] && (rx_byte == p_chr[gi]);
    assign r_eq[gi] = set_on[gi] && (rx_byte == r_chr[gi]);
  end

  assign fc_on      = fc_enabled(enh_en, nine_bit, rx_mode, tx_mode);
  assign pause_hit  = rx_vld && fc_on && (|p_eq);
  assign resume_hit = rx_vld && fc_on && (|r_eq);
  assign spec_hit   = rx_vld && enh_en && spec_en && (rx_byte == pause_b);

endmodule

// File: rtl/rxfc_txgate.sv
module rxfc_txgate (
  input  logic clk,
  input  logic rst_n,
  input  logic fc_on,
  input  logic pause_hit,
  input  logic resume_hit,
  input  logic tx_busy,
  output logic tx_allow
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_allow <= 1'b1;
      pend_q   <= 1'b0;
    end else if (!fc_on) begin
      tx_allow <= 1'b1;
      pend_q   <= 1'b0;
    end else if (pause_hit) begin
      if (tx_busy) begin
        pend_q <= 1'b1;
      end else begin
        tx_allow <= 1'b0;
        pend_q   <= 1'b0;
      end
    end else if (resume_hit) begin
      tx_allow <= 1'b1;
      pend_q   <= 1'b0;
    end else if (pend_q && !tx_busy) begin
      tx_allow <= 1'b0;
      pend_q   <= 1'b0;
    end
  end

  p_idle_allow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_on |=> tx_allow);
  p_pause_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_hit && !tx_busy) |=> !tx_allow);
  p_pause_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_hit && tx_busy && tx_allow) |=> tx_allow);
  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_hit && !pause_hit) |=> tx_allow);

endmodule

// File: rtl/rxfc_rxpath.sv
module rxfc_rxpath (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_vld,
  input  logic pause_hit,
  input  logic resume_hit,
  input  logic spec_hit,
  input  logic spec_ie,
  input  logic irq_clr,
  output logic push_fifo,
  output logic irq
);
  logic consumed;
  logic irq_set;

  assign consumed = (pause_hit || resume_hit) && !spec_hit;
  assign irq_set  = spec_hit && spec_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_fifo <= 1'b0;
      irq       <= 1'b0;
    end else begin
      push_fifo <= rx_vld && !consumed;
      if (irq_set)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  p_no_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_vld |=> !push_fifo);
  p_spec_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spec_hit |=> push_fifo);
  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> irq);
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

endmodule

// File: rtl/rxfc_gate.sv
module rxfc_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_vld,
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] pause_a,
  input  logic [DW-1:0] pause_b,
  input  logic [DW-1:0] resume_a,
  input  logic [DW-1:0] resume_b,
  input  logic [1:0]    rx_mode,
  input  logic [1:0]    tx_mode,
  input  logic          enh_en,
  input  logic          spec_en,
  input  logic          spec_ie,
  input  logic          nine_bit,
  input  logic          tx_busy,
  input  logic          irq_clr,
  output logic          tx_allow,
  output logic          push_fifo,
  output logic          irq
);
  logic fc_on;
  logic pause_hit;
  logic resume_hit;
  logic spec_hit;

  rxfc_match #(.DW(DW)) u_match (
    .rx_vld    (rx_vld),
    .rx_byte   (rx_byte),
    .pause_a   (pause_a),
    .pause_b   (pause_b),
    .resume_a  (resume_a),
    .resume_b  (resume_b),
    .rx_mode   (rx_mode),
    .tx_mode   (tx_mode),
    .enh_en    (enh_en),
    .spec_en   (spec_en),
    .nine_bit  (nine_bit),
    .fc_on     (fc_on),
    .pause_hit (pause_hit),
    .resume_hit(resume_hit),
    .spec_hit  (spec_hit)
  );

  rxfc_txgate u_txgate (
    .clk       (clk),
    .rst_n     (rst_n),
    .fc_on     (fc_on),
    .pause_hit (pause_hit),
    .resume_hit(resume_hit),
    .tx_busy   (tx_busy),
    .tx_allow  (tx_allow)
  );

  rxfc_rxpath u_rxpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_vld    (rx_vld),
    .pause_hit (pause_hit),
    .resume_hit(resume_hit),
    .spec_hit  (spec_hit),
    .spec_ie   (spec_ie),
    .irq_clr   (irq_clr),
    .push_fifo (push_fifo),
    .irq       (irq)
  );

  p_hit_needs_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_hit || resume_hit) |-> fc_on);

endmodule

// File: tb/rxfc_gate_tb_top.sv
module rxfc_gate_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_vld = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic [DW-1:0] pause_a = 8'h13, pause_b = 8'h93, resume_a = 8'h11, resume_b = 8'h91;
  logic [1:0] rx_mode = 2'b00, tx_mode = 2'b00;
  logic enh_en = 1'b0, spec_en = 1'b0, spec_ie = 1'b0, nine_bit = 1'b0;
  logic tx_busy = 1'b0, irq_clr = 1'b0;
  logic tx_allow, push_fifo, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic e_allow, e_pend, e_push, e_irq;
  string t_allow, t_push;

  always #4 clk = ~clk;

  rxfc_gate #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .pause_a(pause_a), .pause_b(pause_b), .resume_a(resume_a), .resume_b(resume_b),
    .rx_mode(rx_mode), .tx_mode(tx_mode), .enh_en(enh_en), .spec_en(spec_en),
    .spec_ie(spec_ie), .nine_bit(nine_bit), .tx_busy(tx_busy), .irq_clr(irq_clr),
    .tx_allow(tx_allow), .push_fifo(push_fifo), .irq(irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Restatement of the activity rule (R2) as a table of accepted combinations.
  function automatic logic m_active();
    if (!enh_en || nine_bit) return 1'b0;
    case (rx_mode)
      2'b01, 2'b10: return 1'b1;
      2'b11:        return tx_mode == 2'b01 || tx_mode == 2'b10;
      default:      return 1'b0;
    endcase
  endfunction

  // R3: which characters each mode compares against
  function automatic logic m_pause();
    logic a, b;
    a = (rx_byte == pause_a);
    b = (rx_byte == pause_b);
    case (rx_mode)
      2'b01:   return b;
      2'b10:   return a;
      2'b11:   return a | b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic m_resume();
    logic a, b;
    a = (rx_byte == resume_a);
    b = (rx_byte == resume_b);
    case (rx_mode)
      2'b01:   return b;
      2'b10:   return a;
      2'b11:   return a | b;
      default: return 1'b0;
    endcase
  endfunction

  // Compute next expected outputs from present inputs, then check at next negedge.
  task automatic step();
    logic act, ph, rh, sp;
    act = m_active();
    ph = rx_vld && act && m_pause();
    rh = rx_vld && act && m_resume();
    sp = rx_vld && enh_en && spec_en && (rx_byte == pause_b);
    t_allow = "R3";
    if (!act) begin
      e_allow = 1'b1; e_pend = 1'b0; t_allow = "R2";
    end else if (ph) begin
      if (tx_busy) begin e_pend = 1'b1; t_allow = "R5"; end
      else begin e_allow = 1'b0; e_pend = 1'b0; t_allow = "R4"; end
    end else if (rh) begin
      e_allow = 1'b1; e_pend = 1'b0; t_allow = "R6";
    end else if (e_pend && !tx_busy) begin
      e_allow = 1'b0; e_pend = 1'b0; t_allow = "R5";
    end
    if (sp) begin
      e_push = 1'b1; t_push = "R8";
    end else begin
      e_push = rx_vld && !(ph || rh); t_push = "R7";
    end
    if (sp && spec_ie) e_irq = 1'b1;
    else if (irq_clr)  e_irq = 1'b0;
    @(negedge clk);
    chk(t_allow, tx_allow, e_allow, "tx_allow");
    chk(t_push, push_fifo, e_push, "push_fifo");
    chk("R9", irq, e_irq, "irq");
  endtask

  task automatic idle();
    rx_vld = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic rx(input logic [DW-1:0] b);
    rx_vld = 1'b1; rx_byte = b;
    step();
    rx_vld = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    chk("R1", tx_allow, 1'b1, "tx_allow reset");
    chk("R1", push_fifo, 1'b0, "push_fifo reset");
    chk("R1", irq, 1'b0, "irq reset");
    e_allow = 1'b1; e_pend = 1'b0; e_push = 1'b0; e_irq = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R2: mode 11 with transmit mode 00 stays disabled, byte pushed
    enh_en = 1'b1; rx_mode = 2'b11; tx_mode = 2'b00;
    rx(pause_a);
    // R5: pause while shifting, held until idle (mode 10)
    rx_mode = 2'b10; tx_busy = 1'b1;
    rx(pause_a);
    step();
    tx_busy = 1'b0;
    step();
    // R6: resume reopens
    rx(resume_a);
    // R4 and R3: mode 01 ignores set A, uses set B
    rx_mode = 2'b01;
    rx(pause_a);
    rx(pause_b);
    rx(resume_b);
    // R5 collision: pause arrives as busy falls, then drop on next idle edge
    tx_busy = 1'b1; rx_mode = 2'b11; tx_mode = 2'b10;
    rx(pause_a);
    tx_busy = 1'b0;
    rx(8'h55);
    rx(resume_b);
    // R2: nine-bit kills detection
    nine_bit = 1'b1;
    rx(pause_b);
    nine_bit = 1'b0;
    // R8/R9: special hit with simultaneous clear, hit wins
    spec_en = 1'b1; spec_ie = 1'b1; irq_clr = 1'b1;
    rx(pause_b);
    irq_clr = 1'b0; step();
    irq_clr = 1'b1; step();
    irq_clr = 1'b0;
    // R9: interrupt enable low, no set
    spec_ie = 1'b0;
    rx(pause_b);
    rx(resume_b);
    // R6: pause and resume equal, pause wins
    resume_a = pause_a; rx_mode = 2'b10;
    rx(pause_a);
    resume_a = 8'h11;
    rx(resume_a);

    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc % 64 == 0) begin
        enh_en   = ($urandom % 8) != 0;
        nine_bit = ($urandom % 8) == 0;
        rx_mode  = 2'($urandom);
        tx_mode  = 2'($urandom);
        spec_en  = $urandom % 2;
        spec_ie  = $urandom % 2;
        pause_a  = 8'($urandom); pause_b = 8'($urandom);
        resume_a = 8'($urandom); resume_b = 8'($urandom);
        if ($urandom % 4 == 0) resume_b = pause_b;
        if ($urandom % 4 == 0) resume_a = pause_b;
      end
      rx_vld  = ($urandom % 3) != 0;
      tx_busy = ($urandom % 2) != 0;
      irq_clr = ($urandom % 5) == 0;
      case ($urandom % 6)
        0: rx_byte = pause_a;
        1: rx_byte = pause_b;
        2: rx_byte = resume_a;
        3: rx_byte = resume_b;
        default: rx_byte = 8'($urandom);
      endcase
      step();
    end
    idle();
    step();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule